// File: doc/BRIEF.md
# Four-Vector Mirrored PWM Sequencer

This block turns one space-vector solution into gate drive for a three-level neutral-point-clamped inverter. Each switching period it receives four per-phase level vectors and four on-times from an upstream nearest-vector search. The vectors arrive already ordered so that neighbours differ by as few switch transitions as possible, and the block never reorders them. It plays the vectors out in a mirrored pattern of seven segments. The outer six segments each get half of their on-time. The fourth vector sits alone in the centre for its full on-time.

A period counter runs in on-time ticks. It is compared against the running sums of the seven segment lengths to find the active segment, and that segment picks one of the four captured vectors. Each phase level of the chosen vector is mapped to the four switches of its leg, giving twelve gate lines. A fresh set of vectors and times is taken only when the counter wraps, so each period is built from one consistent solution. Dead-time insertion belongs to a later stage.

Top module: `svp4_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next cycle shows all twelve gate lines low and `seg_o` = 0. The period counter restarts at zero.
- R2: Within a period, `seg_o` steps through 0 to 6 and selects vectors in the order 1, 2, 3, 4, 3, 2, 1. `seg_o` never exceeds 6.
- R3: Segments 0 and 6 last floor(T1/2) ticks, segments 1 and 5 last floor(T2/2), segments 2 and 4 last floor(T3/2), and segment 3 lasts T4. The period is the sum of these lengths, with on-times 8 bits wide.
- R4: A segment whose length is zero never appears on `seg_o` or the gates. If all seven lengths are zero, the period is one tick long and shows the centre vector.
- R5: Vectors and on-times are captured only at the edge where the counter wraps to zero. Input changes at any other time do not affect the period in progress.
- R6: Phase p of a vector is the level in bits [2p+1:2p]. Its gates are `gate_o[4p+3:4p]` = {S1,S2,S3,S4}. Level 2 gives 1100, level 1 gives 0110, level 0 gives 0011, and the unused code 3 gives 0000.
- R7: `gate_o` and `seg_o` are registered. They show, one clock later, the segment that the counter position selected.
- R8: In each leg, S1 and S3 are never on together, and S2 and S4 are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one on-time unit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| vec1 | input | 6 | First (outer) vector, 2-bit level per phase |
| vec2 | input | 6 | Second vector |
| vec3 | input | 6 | Third vector |
| vec4 | input | 6 | Centre vector |
| ton1 | input | 8 | On-time of vector 1 in ticks |
| ton2 | input | 8 | On-time of vector 2 in ticks |
| ton3 | input | 8 | On-time of vector 3 in ticks |
| ton4 | input | 8 | On-time of vector 4 in ticks |
| gate_o | output | 12 | Gate lines, four per phase leg |
| seg_o | output | 3 | Active segment number, 0..6 |

## Verification
The bench builds the block with its default parameters: three phases, 2-bit levels and 8-bit on-times. Short on-times keep a period to ten or twenty ticks, so many wraps, odd halvings and zero-length segments fit into a few hundred cycles. The 8-bit width also makes the longest period, 1017 ticks with all on-times at 255, cheap to run in full. A behavioural model predicts the segment and gate word every cycle, including inputs that change mid-period and the unused level code.

// File: rtl/svp4_pkg.sv
// Shared types and the per-leg gate mapping for the four-vector sequencer.
// Assumes a three-level leg with switches S1..S4 from the positive rail.
package svp4_pkg;

    localparam int LVL_W   = 2;
    localparam int N_VEC   = 4;
    localparam int N_SEG   = 7;
    localparam int LEG_SW  = 4;

    typedef enum logic [2:0] {
        SEG_OUT1  = 3'd0,
        SEG_OUT2  = 3'd1,
        SEG_OUT3  = 3'd2,
        SEG_MID   = 3'd3,
        SEG_RET3  = 3'd4,
        SEG_RET2  = 3'd5,
        SEG_RET1  = 3'd6
    } seg_e;

    localparam logic [LVL_W-1:0] LVL_NEG  = 2'd0;
    localparam logic [LVL_W-1:0] LVL_ZERO = 2'd1;
    localparam logic [LVL_W-1:0] LVL_POS  = 2'd2;

    // Leg level to {S1,S2,S3,S4}; the unused code turns the leg off.
    function automatic logic [LEG_SW-1:0] leg_gates(input logic [LVL_W-1:0] lvl);
        case (lvl)
            LVL_POS:  leg_gates = 4'b1100;
            LVL_ZERO: leg_gates = 4'b0110;
            LVL_NEG:  leg_gates = 4'b0011;
            default:  leg_gates = 4'b0000;
        endcase
    endfunction

    // Mirrored segment to vector slot (0-based).
    function automatic logic [1:0] seg_slot(input seg_e s);
        case (s)
            SEG_OUT1, SEG_RET1: seg_slot = 2'd0;
            SEG_OUT2, SEG_RET2: seg_slot = 2'd1;
            SEG_OUT3, SEG_RET3: seg_slot = 2'd2;
            default:            seg_slot = 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/svp4_timebase.sv
// Period counter and segment finder.
// Holds the on-times captured at the last wrap, builds the seven mirrored
// segment lengths, and reports the first segment whose running end is
// beyond the counter. Zero-length segments are never chosen because their
// end equals the end of the segment before them.
module svp4_timebase
    import svp4_pkg::*;
#(
    parameter int TIME_W = 8,
    parameter int CNT_W  = TIME_W + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_VEC-1:0][TIME_W-1:0]   ton_in,
    output logic                           load_o,
    output seg_e                           seg_o,
    output logic [CNT_W-1:0]               cnt_o,
    output logic [CNT_W-1:0]               last_o,
    output logic [N_VEC-1:0][TIME_W-1:0]   ton_hold_o
);

    logic [N_VEC-1:0][TIME_W-1:0]  ton_q;
    logic [N_SEG-1:0][TIME_W-1:0]  seg_len;
    logic [N_SEG-1:0][CNT_W-1:0]   seg_end;
    logic [CNT_W-1:0]              cnt_q;
    logic [CNT_W-1:0]              period_len;
    logic [CNT_W-1:0]              last_cnt;
    seg_e                          seg_pick;

    // Segment lengths: mirrored halves outside, full centre time.
    for (genvar k = 0; k < N_SEG; k++) begin : g_len
        localparam int SLOT = (k < N_SEG / 2) ? k : (N_SEG - 1 - k);
        if (k == N_SEG / 2) begin : g_mid
            assign seg_len[k] = ton_q[N_VEC-1];
        end else begin : g_side
            assign seg_len[k] = ton_q[SLOT] >> 1;
        end
    end

    // Running end position of every segment.
    always_comb begin
        logic [CNT_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < N_SEG; k++) begin
            acc        = acc + CNT_W'(seg_len[k]);
            seg_end[k] = acc;
        end
    end

    assign period_len = seg_end[N_SEG-1];
    assign last_cnt   = (period_len == '0) ? '0 : period_len - 1'b1;

    // Lowest segment whose end lies beyond the counter; centre if none.
    always_comb begin
        seg_pick = SEG_MID;
        for (int k = N_SEG - 1; k >= 0; k--) begin
            if (cnt_q < seg_end[k]) seg_pick = seg_e'(3'(k));
        end
    end

    assign load_o = (cnt_q >= last_cnt);

    // Counter advance and wrap with on-time capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ton_q <= '0;
        end else if (load_o) begin
            cnt_q <= '0;
            ton_q <= ton_in;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign seg_o      = seg_pick;
    assign cnt_o      = cnt_q;
    assign last_o     = last_cnt;
    assign ton_hold_o = ton_q;

endmodule

// File: rtl/svp4_vec_hold.sv
// Vector capture and selection.
// Stores the four vectors at each wrap and hands out the one that the
// current segment names. Assumes load comes from the timebase.
module svp4_vec_hold
    import svp4_pkg::*;
#(
    parameter int N_PH  = 3,
    parameter int VEC_W = N_PH * LVL_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_i,
    input  logic [N_VEC-1:0][VEC_W-1:0]  vec_in,
    input  seg_e                         seg_i,
    output logic [VEC_W-1:0]             vec_o
);

    logic [N_VEC-1:0][VEC_W-1:0] vec_q;

    // Capture the vector set at the period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (load_i) vec_q <= vec_in;
    end

    // Segment picks a slot through the mirror table.
    assign vec_o = vec_q[seg_slot(seg_i)];

endmodule

// File: rtl/svp4_gate_map.sv
// Level-to-gate translation and output registers.
// Each phase level becomes four switch commands; the gate word and the
// segment number are registered together so they stay aligned.
module svp4_gate_map
    import svp4_pkg::*;
#(
    parameter int N_PH  = 3,
    parameter int VEC_W = N_PH * LVL_W,
    parameter int GATE_W = N_PH * LEG_SW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VEC_W-1:0]   vec_i,
    input  seg_e               seg_i,
    output logic [GATE_W-1:0]  gate_o,
    output logic [2:0]         seg_o
);

    logic [GATE_W-1:0] gate_d;
    logic [GATE_W-1:0] gate_q;
    logic [2:0]        seg_q;

    for (genvar p = 0; p < N_PH; p++) begin : g_leg
        assign gate_d[LEG_SW*p +: LEG_SW] = leg_gates(vec_i[LVL_W*p +: LVL_W]);
    end

    // Register gate word and segment number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= '0;
            seg_q  <= '0;
        end else begin
            gate_q <= gate_d;
            seg_q  <= seg_i;
        end
    end

    assign gate_o = gate_q;
    assign seg_o  = seg_q;

endmodule

// File: rtl/svp4_sequencer.sv
// Four-vector mirrored PWM sequencer, top level.
// Plays four pre-ordered vectors as 1,2,3,4,3,2,1 with half on-times on the
// sides and the full fourth time in the centre, one tick per clock.
// Assumes the inputs are held valid around each period wrap.
module svp4_sequencer
    import svp4_pkg::*;
#(
    parameter int N_PH   = 3,
    parameter int TIME_W = 8,
    localparam int VEC_W  = N_PH * LVL_W,
    localparam int GATE_W = N_PH * LEG_SW,
    localparam int CNT_W  = TIME_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VEC_W-1:0]  vec1,
    input  logic [VEC_W-1:0]  vec2,
    input  logic [VEC_W-1:0]  vec3,
    input  logic [VEC_W-1:0]  vec4,
    input  logic [TIME_W-1:0] ton1,
    input  logic [TIME_W-1:0] ton2,
    input  logic [TIME_W-1:0] ton3,
    input  logic [TIME_W-1:0] ton4,
    output logic [GATE_W-1:0] gate_o,
    output logic [2:0]        seg_o
);

    logic                          load;
    seg_e                          seg_now;
    logic [CNT_W-1:0]              cnt;
    logic [CNT_W-1:0]              last_cnt;
    logic [N_VEC-1:0][TIME_W-1:0]  sh_t;
    logic [VEC_W-1:0]              vec_sel;

    svp4_timebase #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ton_in     ({ton4, ton3, ton2, ton1}),
        .load_o     (load),
        .seg_o      (seg_now),
        .cnt_o      (cnt),
        .last_o     (last_cnt),
        .ton_hold_o (sh_t)
    );

    svp4_vec_hold #(.N_PH(N_PH), .VEC_W(VEC_W)) u_vh (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .vec_in ({vec4, vec3, vec2, vec1}),
        .seg_i  (seg_now),
        .vec_o  (vec_sel)
    );

    svp4_gate_map #(.N_PH(N_PH), .VEC_W(VEC_W), .GATE_W(GATE_W)) u_gm (
        .clk    (clk),
        .rst_n  (rst_n),
        .vec_i  (vec_sel),
        .seg_i  (seg_now),
        .gate_o (gate_o),
        .seg_o  (seg_o)
    );

endmodule

// File: rtl/svp4_sequencer_chk.sv
// Property checker for the sequencer, attached by bind below.
// Watches the output word, the counter and the held on-times.
module svp4_sequencer_chk #(
    parameter int GATE_W = 12,
    parameter int CNT_W  = 10,
    parameter int HOLD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GATE_W-1:0] gate_o,
    input logic [2:0]        seg_o,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  last_cnt,
    input logic [HOLD_W-1:0] sh_t
);

    function automatic logic leg_ok(input logic [3:0] n);
        return (n == 4'b1100) || (n == 4'b0110) || (n == 4'b0011) || (n == 4'b0000);
    endfunction

    // R1: a reset edge leaves the outputs cleared.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (gate_o == '0) && (seg_o == 3'd0));

    // R2: the segment number stays within the seven segments.
    assert_seg_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_o <= 3'd6);

    // R3: the counter never runs past the end of the current period.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_cnt);

    // R5: held on-times change only on the cycle the counter returns to zero.
    assert_hold_mid_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(sh_t));

    // R6: every leg shows one of the four legal patterns.
    assert_leg_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        leg_ok(gate_o[3:0]) && leg_ok(gate_o[7:4]) && leg_ok(gate_o[11:8]));

    // R8: outer and inner switch pairs are never on together.
    assert_pairs_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ~|(gate_o & (gate_o >> 2) & 12'h333));

endmodule

bind svp4_sequencer svp4_sequencer_chk #(
    .GATE_W (GATE_W),
    .CNT_W  (CNT_W),
    .HOLD_W (4 * TIME_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate_o   (gate_o),
    .seg_o    (seg_o),
    .cnt      (cnt),
    .last_cnt (last_cnt),
    .sh_t     (sh_t)
);

// File: tb/sim_svp4_sequencer.sv
`timescale 1ns/1ps
module sim_svp4_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  vv [4];
    logic [7:0]  tt [4];
    logic [11:0] gate_o;
    logic [2:0]  seg_o;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;
    string cur_req = "R1";

    // behavioural model state
    int       m_cnt;
    int       m_t [4];
    logic [5:0] m_v [4];
    logic [11:0] exp_gate;
    int       exp_seg;
    bit       primed = 0;

    always #2.5 clk = ~clk;

    svp4_sequencer u0 (
        .clk(clk), .rst_n(rst_n),
        .vec1(vv[0]), .vec2(vv[1]), .vec3(vv[2]), .vec4(vv[3]),
        .ton1(tt[0]), .ton2(tt[1]), .ton3(tt[2]), .ton4(tt[3]),
        .gate_o(gate_o), .seg_o(seg_o)
    );

    function automatic logic [3:0] leg_of(input logic [1:0] l);
        if (l == 2'd2) return 4'b1100;
        if (l == 2'd1) return 4'b0110;
        if (l == 2'd0) return 4'b0011;
        return 4'b0000;
    endfunction

    function automatic logic [11:0] word_of(input logic [5:0] v);
        return {leg_of(v[5:4]), leg_of(v[3:2]), leg_of(v[1:0])};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare against the model, then advance it across the coming edge.
    task automatic step();
        int d [7];
        int ord [7] = '{0, 1, 2, 3, 2, 1, 0};
        int acc, seg, len;
        if (primed) begin
            check(gate_o === exp_gate, cur_req, "gate", int'(gate_o), int'(exp_gate));
            check(int'(seg_o) == exp_seg, cur_req, "seg", int'(seg_o), exp_seg);
        end
        primed = 1;
        if (!rst_n) begin
            m_cnt = 0;
            foreach (m_t[i]) begin m_t[i] = 0; m_v[i] = '0; end
            exp_gate = '0;
            exp_seg  = 0;
        end else begin
            d = '{m_t[0]/2, m_t[1]/2, m_t[2]/2, m_t[3], m_t[2]/2, m_t[1]/2, m_t[0]/2};
            len = 0;
            foreach (d[i]) len += d[i];
            seg = 3;
            acc = 0;
            for (int i = 0; i < 7; i++) begin
                acc += d[i];
                if (m_cnt < acc) begin seg = i; break; end
            end
            exp_seg  = seg;
            exp_gate = word_of(m_v[ord[seg]]);
            if (len == 0 || m_cnt >= len - 1) begin
                m_cnt = 0;
                foreach (m_t[i]) begin m_t[i] = tt[i]; m_v[i] = vv[i]; end
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic set_t(input int a, input int b, input int c, input int e);
        tt[0] = 8'(a); tt[1] = 8'(b); tt[2] = 8'(c); tt[3] = 8'(e);
    endtask

    task automatic set_v(input logic [5:0] a, input logic [5:0] b,
                         input logic [5:0] c, input logic [5:0] e);
        vv[0] = a; vv[1] = b; vv[2] = c; vv[3] = e;
    endtask

    initial begin
        int bad;
        set_v(6'b000000, 6'b000001, 6'b000101, 6'b010101);
        set_t(4, 6, 8, 5);
        @(negedge clk);
        cur_req = "R1";
        run(3);
        check(gate_o == 12'h000 && seg_o == 3'd0, "R1", "reset outputs",
              int'({gate_o, 1'b0, seg_o}), 0);
        rst_n = 1'b1;
        cur_req = "R7"; run(2);
        cur_req = "R2"; run(70);
        // odd on-times round down
        cur_req = "R3"; set_t(5, 3, 7, 1); run(40);
        // zero-length segments never appear
        cur_req = "R4"; set_t(6, 0, 1, 4); run(30);
        bad = 0;
        for (int i = 0; i < 26; i++) begin
            step();
            if (seg_o inside {3'd1, 3'd2, 3'd4, 3'd5}) bad++;
        end
        check(bad == 0, "R4", "zero segment shown", bad, 0);
        set_t(0, 0, 0, 0); run(15);
        check(seg_o == 3'd3, "R4", "all-zero centre", int'(seg_o), 3);
        set_t(1, 1, 0, 9); run(25);
        // longest period
        cur_req = "R3"; set_t(255, 255, 255, 255); run(2100);
        // legal, mixed and unused level codes
        cur_req = "R6";
        set_v(6'b101010, 6'b111001, 6'b011011, 6'b111111);
        set_t(2, 2, 2, 2);
        run(1050);
        bad = 0;
        for (int i = 0; i < 24; i++) begin
            step();
            if (seg_o == 3'd0 && gate_o !== 12'hccc) bad++;
            if (seg_o == 3'd3 && gate_o !== 12'h000) bad++;
        end
        check(bad == 0, "R6", "level map", bad, 0);
        // mid-period input changes
        cur_req = "R5"; set_t(10, 10, 10, 10); run(60);
        for (int k = 0; k < 20; k++) begin
            set_t((k * 7) % 23, (k * 5) % 17, (k * 3) % 29, (k * 11) % 13);
            set_v(6'((k * 13) % 64), 6'((k * 29) % 64), 6'((k * 7) % 64), 6'((k * 37) % 64));
            run(7);
        end
        cur_req = "R8"; set_v(6'b000000, 6'b100001, 6'b011010, 6'b101010);
        set_t(3, 4, 5, 6); run(40);
        // reset in mid-run
        cur_req = "R1"; rst_n = 1'b0; run(2);
        check(gate_o == 12'h000 && seg_o == 3'd0, "R1", "mid-run reset",
              int'(gate_o), 0);
        rst_n = 1'b1; cur_req = "R7"; run(30);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule